// File: doc/BRIEF.md
# Infrared Edge Capture Timer

This block times the gaps between transitions on an infrared receive line. A software-visible control word picks which transitions count, and also picks what drives the timer. The timer can run on whole periods of an internal carrier, whose high and low phase lengths are programmable. It can also run on every pulse of a reference clock enable, which gives finer resolution.

The first qualifying transition after the block is enabled arms the timer. From then on, every qualifying transition copies the running count into a capture register, restarts the count from zero and raises a sticky capture flag. A count that rolls over its maximum raises a sticky overflow flag. The interrupt line is high while either flag is set. Software clears the flags by writing ones to a clear location.

Register map (select value on `cfg_sel`): 0 = control, 1 = carrier high reload, 2 = carrier low reload, 3 = flag clear (write ones). The control word has the following fields:
- bit 0: enable.
- bit 1: direction, where 1 means transmit and the receive logic is idle.
- bits 3:2: edge select.
- bit 4: clock source, where 1 means reference pulses and 0 means carrier periods.

Top module: `ir_interval_capture`

## Requirements
- R1: After reset `cap_value` is 0 and `irq` is 0.
- R2: Receive logic runs only when the control enable bit (bit 0) is 1 and the direction bit (bit 1) is 0. Otherwise pin transitions leave `cap_value` unchanged and set no flag.
- R3: Edge select (control bits 3:2) works as follows: 00 qualifies only falling transitions, 01 only rising, 10 both, and 11 also both. Transitions that do not qualify change nothing.
- R4: The first qualifying transition after the block becomes active only arms the timer. It makes no capture and sets no flag.
- R5: With the clock source bit (bit 4) at 1, the count advances once per clock cycle in which `ref_tick` is 1, and holds while `ref_tick` is 0. With `ref_tick` held at 1, a gap of N cycles between qualifying transitions captures (N-1) modulo 2^CNT_W.
- R6: With the clock source bit at 0, the count advances once per carrier period. A period is (high reload + 1) plus (low reload + 1) `ref_tick` pulses. The carrier restarts its high phase on each qualifying transition. With `ref_tick` at 1, a gap of N cycles captures floor((N-1)/period).
- R7: On each qualifying transition while armed, the count is copied to `cap_value` and the count returns to 0. The new value appears three clock edges after the pin changes, because two synchronizer stages and one capture stage lie on the way.
- R8: When the count advances from its maximum value it wraps to 0 and sets the sticky overflow flag.
- R9: `irq` is the OR of the sticky capture flag and the sticky overflow flag. Writing to select 3 clears the capture flag when data bit 0 is 1 and the overflow flag when data bit 1 is 1. An event in the same cycle as a clear wins.
- R10: Leaving the active state holds the count at 0 and disarms the timer. After re-enabling, the next qualifying transition only arms again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference clock enable pulse |
| rx_pin | input | 1 | Raw infrared receive line |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | DATA_W | Register write data |
| cap_value | output | CNT_W | Last captured interval |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 6-bit counter and 4-bit carrier reloads. With these sizes, counter wrap is reached within about seventy cycles, and every carrier period from two to eight ticks can be swept. Expected captures are computed from the gap length with modular and floor-division arithmetic. The bench sweeps every edge-select code in reference mode and a grid of high and low reloads in carrier mode. It also stalls the reference pulse and toggles the enable and direction bits, to show that pin activity is ignored and that arming starts over.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      clk_src;   // 1: reference pulses, 0: carrier periods
    edge_sel_e edge_sel;
    logic      tx_dir;    // 1: transmit, receive logic idle
    logic      en;
  } ctrl_t;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_HI    = 2'd1;
  localparam logic [1:0] SEL_LO    = 2'd2;
  localparam logic [1:0] SEL_CLEAR = 2'd3;

endpackage

// File: rtl/ir_rx_edge.sv
module ir_rx_edge
  import ir_cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      rx,
  input  edge_sel_e sel,
  output logic      qual
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] shr;
  logic          cur, prev;

  always_ff @(posedge clk) begin
    if (rst) shr <= '0;
    else     shr <= {shr[LAST-1:0], rx};
  end

  assign cur  = shr[LAST-1];
  assign prev = shr[LAST];

  always_comb begin
    unique case (sel)
      EDGE_FALL: qual = prev & ~cur;
      EDGE_RISE: qual = ~prev & cur;
      default:   qual = prev ^ cur;
    endcase
  end
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int RLD_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [RLD_W-1:0] hi_rld,
  input  logic [RLD_W-1:0] lo_rld,
  output logic             cyc_done
);
  logic             low_ph;
  logic [RLD_W-1:0] ph_cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      low_ph <= 1'b0;
      ph_cnt <= '0;
    end else if (tick) begin
      if (!low_ph && ph_cnt == hi_rld) begin
        low_ph <= 1'b1;
        ph_cnt <= '0;
      end else if (low_ph && ph_cnt == lo_rld) begin
        low_ph <= 1'b0;
        ph_cnt <= '0;
      end else begin
        ph_cnt <= ph_cnt + 1'b1;
      end
    end
  end

  assign cyc_done = tick && low_ph && (ph_cnt == lo_rld) && !restart;
endmodule

// File: rtl/ir_interval_cnt.sv
module ir_interval_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             qe,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap,
  output logic             started,
  output logic             cap_evt,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cap     <= '0;
      started <= 1'b0;
    end else if (!active) begin
      cnt     <= '0;
      started <= 1'b0;
    end else if (qe) begin
      started <= 1'b1;
      cnt     <= '0;
      if (started) cap <= cnt;
    end else if (started && adv) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cap_evt  = active && qe && started;
  assign wrap_evt = active && started && !qe && adv && (cnt == CNT_MAX);
endmodule

// File: rtl/ir_interval_capture.sv
module ir_interval_capture
  import ir_cap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int RLD_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              rx_pin,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0]  cap_value,
  output logic              irq
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [RLD_W-1:0] hi_q, lo_q;
  logic             cap_flag, ovf_flag;
  logic             active, qual_edge, cyc_done, adv;
  logic             started, cap_evt, wrap_evt, clr_hit;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (cfg_we) begin
      unique case (cfg_sel)
        SEL_CTRL: ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        SEL_HI:   hi_q   <= cfg_wdata[RLD_W-1:0];
        SEL_LO:   lo_q   <= cfg_wdata[RLD_W-1:0];
        default:  ;
      endcase
    end
  end

  assign active  = ctrl_q.en && !ctrl_q.tx_dir;
  assign clr_hit = cfg_we && (cfg_sel == SEL_CLEAR);

  ir_rx_edge #(.SYNC_STAGES(2)) u_edge (
    .clk (clk),
    .rst (rst),
    .rx  (rx_pin),
    .sel (ctrl_q.edge_sel),
    .qual(qual_edge)
  );

  ir_carrier_gen #(.RLD_W(RLD_W)) u_car (
    .clk     (clk),
    .rst     (rst),
    .restart (!active || qual_edge),
    .tick    (ref_tick),
    .hi_rld  (hi_q),
    .lo_rld  (lo_q),
    .cyc_done(cyc_done)
  );

  assign adv = ctrl_q.clk_src ? ref_tick : cyc_done;

  ir_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .qe      (qual_edge),
    .adv     (adv),
    .cnt     (cnt),
    .cap     (cap_value),
    .started (started),
    .cap_evt (cap_evt),
    .wrap_evt(wrap_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      cap_flag <= cap_evt  || (cap_flag && !(clr_hit && cfg_wdata[0]));
      ovf_flag <= wrap_evt || (ovf_flag && !(clr_hit && cfg_wdata[1]));
    end
  end

  assign irq = cap_flag || ovf_flag;
endmodule

// File: rtl/ir_cap_checker.sv
module ir_cap_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             active,
  input logic             qe,
  input logic             started,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cap,
  input logic             irq
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(cap));

  p_disarm_r10: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt == '0 && !started));

  p_first_arm_r4: assert property (@(posedge clk) disable iff (rst)
    (active && qe && !started) |=> ($stable(cap) && started));

  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    (active && qe && started) |=> (cap == $past(cnt) && cnt == '0));

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> (cnt == '0 || cnt == CNT_W'($past(cnt) + 1'b1)));

  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (irq && cnt == '0));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(active && ((qe && started) || wrap)));
endmodule

bind ir_interval_capture ir_cap_checker #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .active (active),
  .qe     (qual_edge),
  .started(started),
  .wrap   (wrap_evt),
  .cnt    (cnt),
  .cap    (cap_value),
  .irq    (irq)
);

// File: tb/test_ir_interval_capture.sv
module test_ir_interval_capture;
  localparam int CNT_W = 6;
  localparam int RLD_W = 4;
  localparam int MODV  = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b1;
  logic rx_pin = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [CNT_W-1:0] cap_value;
  logic irq;

  int nvec = 0, nfail = 0;
  bit done = 0;

  // bench model state
  bit m_started = 0;
  bit m_active  = 0;
  int m_sel = 0, m_src = 1, m_per = 2;
  int m_cap = 0, since = 0;

  always #5 clk = ~clk;

  ir_interval_capture #(.CNT_W(CNT_W), .RLD_W(RLD_W), .DATA_W(16)) i_ir_interval_capture (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .rx_pin(rx_pin),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cap_value(cap_value), .irq(irq)
  );

  task automatic check(string tag, int got, int exp);
    nvec++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg(bit en, bit dir, int sel, int src);
    wr(2'd0, 16'((src << 4) | (sel << 2) | (int'(dir) << 1) | int'(en)));
    m_active = en && !dir;
    m_sel = sel; m_src = src;
    if (!m_active) m_started = 0;
  endtask

  // change the pin at a falling edge, then hold it for n cycles (n >= 7)
  task automatic drive(bit lvl, int n);
    bit q;
    int expv;
    rx_pin = lvl;
    q = m_active && ((m_sel == 0 && !lvl) || (m_sel == 1 && lvl) || m_sel >= 2);
    if (q && m_started) begin
      if (!ref_tick)   expv = 0;
      else if (m_src)  expv = (since - 1) % MODV;
      else             expv = (since - 1) / m_per;
      repeat (2) @(negedge clk);
      check("R7 capture latency", cap_value, m_cap);
      @(negedge clk);
      check(m_src ? "R5 reference interval" : "R6 carrier interval", cap_value, expv);
      check("R9 irq on capture", irq, 1);
      m_cap = expv;
      wr(2'd3, 16'h3);
      check("R9 irq cleared", irq, 0);
      repeat (n - 4) @(negedge clk);
    end else begin
      repeat (3) @(negedge clk);
      if (q)             check("R4 arm only", cap_value, m_cap);
      else if (m_active) check("R3 edge not qualified", cap_value, m_cap);
      else               check("R2 inactive ignores pin", cap_value, m_cap);
      check(q ? "R10 irq after arm" : "R3 R2 irq quiet", irq, 0);
      repeat (n - 3) @(negedge clk);
    end
    if (q) begin
      m_started = 1;
      since = n;
    end else begin
      since = since + n;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset capture", cap_value, 0);
    check("R1 reset irq", irq, 0);

    // reference-clock mode, every edge-select code
    for (int s = 0; s < 4; s++) begin
      cfg(0, 0, s, 1);
      cfg(1, 0, s, 1);
      for (int k = 0; k < 12; k++) drive(!rx_pin, 7 + ((k * 5) % 13));
    end

    // transmit direction and disabled: pin ignored
    cfg(1, 1, 2, 1);
    for (int k = 0; k < 4; k++) drive(!rx_pin, 9);
    cfg(0, 0, 2, 1);
    for (int k = 0; k < 4; k++) drive(!rx_pin, 8);

    // R10: re-enable needs a fresh arming edge
    cfg(1, 0, 2, 1);
    drive(!rx_pin, 10);
    drive(!rx_pin, 12);
    cfg(0, 0, 2, 1);
    cfg(1, 0, 2, 1);
    drive(!rx_pin, 9);
    drive(!rx_pin, 11);

    // R8: wrap and sticky overflow, rising edges only
    cfg(0, 0, 1, 1);
    rx_pin = 1'b0;
    repeat (6) @(negedge clk);
    cfg(1, 0, 1, 1);
    rx_pin = 1'b1;
    repeat (66) @(negedge clk);
    check("R8 before wrap", irq, 0);
    @(negedge clk);
    check("R8 wrap sets overflow", irq, 1);
    wr(2'd3, 16'h1);
    check("R9 capture clear keeps overflow", irq, 1);
    wr(2'd3, 16'h2);
    check("R9 overflow clear", irq, 0);
    repeat (11) @(negedge clk);
    m_started = 1;
    since = 80;
    drive(1'b0, 10);
    drive(1'b1, 10);

    // R5/R6: stalled reference pulse holds the count
    cfg(0, 0, 2, 1);
    ref_tick = 1'b0;
    cfg(1, 0, 2, 1);
    drive(!rx_pin, 8);
    drive(!rx_pin, 9);
    cfg(0, 0, 2, 0);
    cfg(1, 0, 2, 0);
    drive(!rx_pin, 8);
    drive(!rx_pin, 9);
    cfg(0, 0, 2, 0);
    ref_tick = 1'b1;

    // carrier mode sweep over high and low reloads
    for (int h = 0; h < 4; h++) begin
      for (int l = 0; l < 3; l++) begin
        cfg(0, 0, 2, 0);
        wr(2'd1, 16'(h));
        wr(2'd2, 16'(l));
        m_per = h + l + 2;
        cfg(1, 0, (h + l) % 2 == 0 ? 2 : 3, 0);
        for (int k = 0; k < 8; k++) drive(!rx_pin, 7 + ((k * 7 + h) % 17));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule